// File: doc/BRIEF.md
# Disable-Flagged Tick Compare Timer

The block holds a 64-bit compare register whose low 63 bits are a target time and whose top bit is an interrupt-disable flag. It watches an external free-running 63-bit counter. When the counter equals the target and the timer is enabled and armed, it emits a one-cycle match pulse. The system-tick instance feeds that pulse into the set input for soft-interrupt bit 16. The hypervisor instance uses the same pulse to set a one-bit pending flag, and that flag drives a hypervisor interrupt request.

A write to the compare register arms the timer only when the new target lies strictly after the present counter value and the disable flag is clear. Every write replaces the previous target. A disabled write, or a write aimed at the present or a past time, leaves nothing armed. A thread-status input tells the block whether the thread is running, suspended or halted. A match still fires while the thread is suspended. The hypervisor instance throws away a match that lands while the thread is halted.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the compare register reads 0x8000_0000_0000_0000 (disabled, target 0), and the match pulse, the pending flag and the interrupt request are all 0.
- R2: A compare write (wr_sel=0) stores all 64 bits. The register reads back the written value when rd_sel=0.
- R3: A compare write with bit 63 clear and a target strictly greater than count_in at the write edge arms the timer. When count_in equals the target at a clock edge, match_pulse is 1 for exactly the following cycle.
- R4: A compare write whose target is equal to or less than count_in at the write edge arms nothing. No pulse follows for that write.
- R5: A compare write with bit 63 set arms nothing and cancels an earlier armed target. No pulse follows.
- R6: A new compare write replaces any armed target. Only the latest target can produce a pulse.
- R7: A target fires once. Holding count_in at the target for several cycles gives a single pulse.
- R8: With HYPER=1, a match sets the pending flag to 1. The flag reads back as bit 0 when rd_sel=1, and hint_req is 1 while the flag is 1.
- R9: With HYPER=1, a write with wr_sel=1 loads wr_data[0] into the pending flag. Writing 0 drops hint_req.
- R10: With HYPER=1, a match that occurs while thread_st is halted (2'd2) gives no pulse and leaves the pending flag unchanged. With HYPER=0, the thread state has no effect.
- R11: A match fires while thread_st is suspended (2'd1) in both variants. Running is 2'd0.
- R12: With HYPER=0, the pending flag and hint_req stay 0, and writes with wr_sel=1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the compare register, 1 selects the pending flag |
| wr_data | input | 64 | Write data |
| rd_sel | input | 1 | Read select: 0 selects the compare register, 1 selects the pending flag |
| rd_data | output | 64 | Combinational read data |
| count_in | input | 63 | Free-running counter value |
| thread_st | input | 2 | Thread status: 0 running, 1 suspended, 2 halted |
| match_pulse | output | 1 | One-cycle match pulse (soft-interrupt bit 16 set) |
| hint_req | output | 1 | Hypervisor interrupt request |

## Verification
On every cycle the assertions check the following:
- A pulse never follows a cycle in which the disable flag was set.
- A pulse never follows a halted cycle in the hypervisor variant.
- Every pulse is preceded by equality between the counter and the stored target.
- Pulses never come back to back.
- The request only rises after a match or an explicit write of 1.

Only the directed scenarios can show the following:
- Arming depends on the counter value at the write edge.
- A rewrite replaces the earlier target.
- A disabled write cancels an armed target.
- The pending flag reads back correctly and can be cleared.

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int CNT_W = 63,
  parameter bit HYPER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W:0]   wr_data,
  input  logic             rd_sel,
  output logic [CNT_W:0]   rd_data,
  input  logic [CNT_W-1:0] count_in,
  input  logic [1:0]       thread_st,
  output logic             match_pulse,
  output logic             hint_req
);
  localparam int DW = CNT_W + 1;
  localparam logic [1:0] ST_HALT = 2'd2;

  logic [DW-1:0] cmp_q;
  logic          armed_q;
  logic          hint_pend;
  logic          cmp_wr, pend_wr, hit, fire;

  assign cmp_wr  = wr_en && !wr_sel;
  assign pend_wr = wr_en && wr_sel;
  assign hit     = armed_q && !cmp_q[DW-1] && (count_in == cmp_q[CNT_W-1:0]) && !cmp_wr;
  assign fire    = hit && !(HYPER && thread_st == ST_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q       <= {1'b1, {CNT_W{1'b0}}};
      armed_q     <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      match_pulse <= fire;
      if (cmp_wr) begin
        cmp_q   <= wr_data;
        armed_q <= !wr_data[DW-1] && (wr_data[CNT_W-1:0] > count_in);
      end else if (hit) begin
        armed_q <= 1'b0;
      end
    end
  end

  generate
    if (HYPER) begin : g_hv
      always_ff @(posedge clk) begin
        if (!rst_n)       hint_pend <= 1'b0;
        else if (fire)    hint_pend <= 1'b1;
        else if (pend_wr) hint_pend <= wr_data[0];
      end
    end else begin : g_sys
      assign hint_pend = 1'b0;
    end
  endgenerate

  assign hint_req = hint_pend;
  assign rd_data  = rd_sel ? {{CNT_W{1'b0}}, hint_pend} : cmp_q;
endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk #(
  parameter int CNT_W = 63,
  parameter bit HYPER = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [CNT_W:0]   wr_data,
  input logic [CNT_W-1:0] count_in,
  input logic [1:0]       thread_st,
  input logic             match_pulse,
  input logic             hint_req,
  input logic [CNT_W:0]   cmp_q
);
  // R5
  disabled_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q[CNT_W] |=> !match_pulse);

  // R3
  pulse_needs_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(count_in == cmp_q[CNT_W-1:0]));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);

  // R10
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HYPER && thread_st == 2'd2) |=> !match_pulse);

  // R8
  req_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hint_req) |-> (match_pulse || $past(wr_en && wr_sel && wr_data[0])));

  // R12
  sys_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HYPER |-> !hint_req);
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.CNT_W(CNT_W), .HYPER(HYPER)) u_chk (.*);

// File: tb/tick_cmp_timer_bench.sv
module tick_cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic [62:0] cnt = '0;
  logic [1:0]  thread_st = 2'd0;
  logic [63:0] rd_s, rd_h;
  logic        mp_s, mp_h, rq_s, rq_h;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  tick_cmp_timer #(.HYPER(1'b0)) u_tick_cmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_s), .count_in(cnt), .thread_st(thread_st),
    .match_pulse(mp_s), .hint_req(rq_s));

  tick_cmp_timer #(.HYPER(1'b1)) u_tick_cmp_timer_hv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_h), .count_in(cnt), .thread_st(thread_st),
    .match_pulse(mp_h), .hint_req(rq_h));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic sel, logic [63:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_sel = 1'b0;
  endtask

  task automatic t_reset();
    rd_sel = 1'b0; #1;
    chk("R1 cmp", rd_h, 64'h8000_0000_0000_0000);
    chk("R1 pulse", {mp_s, mp_h}, 2'b00);
    chk("R1 req", {rq_s, rq_h}, 2'b00);
    rd_sel = 1'b1; #1;
    chk("R1 pend", rd_h, 64'd0);
    rd_sel = 1'b0;
  endtask

  task automatic t_basic();
    cnt = 63'd100;
    wr(1'b0, 64'd105);
    chk("R2 readback", rd_s, 64'd105);
    cnt = 63'd104; tick();
    chk("R3 early", {mp_s, mp_h}, 2'b00);
    cnt = 63'd105; tick();
    chk("R3 pulse", {mp_s, mp_h}, 2'b11);
    tick();
    chk("R7 hold one pulse", {mp_s, mp_h}, 2'b00);
    tick();
    chk("R7 still quiet", {mp_s, mp_h}, 2'b00);
    chk("R8 req", rq_h, 1'b1);
    rd_sel = 1'b1; #1;
    chk("R8 pend read", rd_h, 64'd1);
    chk("R12 sys pend read", rd_s, 64'd0);
    chk("R12 sys req", rq_s, 1'b0);
    rd_sel = 1'b0;
    wr(1'b1, 64'd0);
    chk("R9 clear", rq_h, 1'b0);
  endtask

  task automatic t_past();
    cnt = 63'd200;
    wr(1'b0, 64'd200);
    tick(); tick();
    chk("R4 equal no pulse", {mp_s, mp_h}, 2'b00);
    wr(1'b0, 64'd150);
    cnt = 63'd210; tick();
    chk("R4 past no pulse", {mp_s, mp_h}, 2'b00);
  endtask

  task automatic t_disable();
    cnt = 63'd300;
    wr(1'b0, 64'h8000_0000_0000_0000 | 64'd320);
    chk("R2 readback dis", rd_s, 64'h8000_0000_0000_0140);
    cnt = 63'd320; tick(); tick();
    chk("R5 disabled", {mp_s, mp_h}, 2'b00);
    wr(1'b0, 64'd340);
    wr(1'b0, 64'h8000_0000_0000_0000 | 64'd340);
    cnt = 63'd340; tick(); tick();
    chk("R5 cancel", {mp_s, mp_h}, 2'b00);
    chk("R5 no req", rq_h, 1'b0);
  endtask

  task automatic t_rewrite();
    cnt = 63'd400;
    wr(1'b0, 64'd460);
    wr(1'b0, 64'd430);
    cnt = 63'd430; tick();
    chk("R6 new target", {mp_s, mp_h}, 2'b11);
    cnt = 63'd460; tick(); tick();
    chk("R6 old target dead", {mp_s, mp_h}, 2'b00);
    wr(1'b1, 64'd0);
  endtask

  task automatic t_thread();
    cnt = 63'd500;
    thread_st = 2'd2;
    wr(1'b0, 64'd510);
    cnt = 63'd510; tick();
    chk("R10 halted sys fires", mp_s, 1'b1);
    chk("R10 halted hv quiet", mp_h, 1'b0);
    tick();
    chk("R10 pend unchanged", rq_h, 1'b0);
    thread_st = 2'd1;
    cnt = 63'd520;
    wr(1'b0, 64'd530);
    cnt = 63'd530; tick();
    chk("R11 suspended fires", {mp_s, mp_h}, 2'b11);
    chk("R11 pend set", rq_h, 1'b1);
    wr(1'b1, 64'd0);
    chk("R9 clear again", rq_h, 1'b0);
    wr(1'b1, 64'd1);
    chk("R9 write one", rq_h, 1'b1);
    chk("R12 sys ignores", rq_s, 1'b0);
    thread_st = 2'd0;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_past();
    t_disable();
    t_rewrite();
    t_thread();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule